// File: doc/BRIEF.md
# Pin Input Debounce Filter Bank

This block cleans up the raw input levels of a parallel GPIO port before they reach the port read-back and the interrupt detection logic. Every pin has its own filter. Each filter runs in one of three modes. In the first, the level passes straight through. In the second, a short glitch filter runs on the bus clock. In the third, a slow filter samples the pin only on a shared timing tick.

The tick comes from a divider on the bus clock. Its period is twice the programmed divider value plus one, counted in clock cycles. A single enable input gates the divider as a whole. Software-side logic loads the per-pin enable word, the per-pin tick-select word and the divider value through plain write strobes. Each word is written in full. A written value takes effect at the next rising clock edge.

Top module: `pin_debounce_bank`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `pins_filt` is all zeros. All enable and select bits reset to 0, and the divider value and its count reset to 0.
- R2: When a pin's enable bit is 0, its filtered output equals that pin's raw input as sampled at the previous rising edge. A one-cycle pulse therefore passes through. The pin's select bit has no effect in this mode.
- R3: When a pin's enable bit is 1 and its select bit is 0, the pin samples its raw input on every clock edge. The output takes the new level only when two consecutive samples agree. A level change held for at least two edges appears two edges after it reaches the input. A one-cycle pulse never reaches the output.
- R4: The divider value is DIVW (default 24) bits wide. When the divider is enabled, it produces one tick every 2 × (value + 1) clock cycles.
- R5: When a pin's enable bit and select bit are both 1, the pin samples its raw input only on tick edges. The output takes the new level only when two consecutive tick samples agree. A pulse that is not seen by two consecutive ticks is ignored, and the output changes on no other edge.
- R6: A divider write restarts the count from zero at the write edge. The first tick edge then comes 2 × (value + 1) cycles after that edge.
- R7: While `dbclk_en` is 0, the divider count is held at zero and no tick occurs. Pins in tick mode keep their output. When `dbclk_en` returns to 1, the first tick edge comes 2 × (value + 1) cycles after the first enabled edge counted from zero.
- R8: Each pin filters independently. With a mixed select word, glitch-mode pins and tick-mode pins follow their own timing in the same cycles.
- R9: A write strobe replaces the whole enable, select or divider word. The new value takes effect from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_pins | input | NPINS | Unfiltered pin levels |
| en_wr | input | 1 | Write strobe for the per-pin filter enable word |
| en_wdata | input | NPINS | New filter enable word |
| sel_wr | input | 1 | Write strobe for the per-pin tick-select word |
| sel_wdata | input | NPINS | New tick-select word |
| div_wr | input | 1 | Write strobe for the divider value |
| div_wdata | input | DIVW | New divider value |
| dbclk_en | input | 1 | Enables the shared tick divider |
| pins_filt | output | NPINS | Filtered pin levels toward port and interrupt logic |

## Verification
The bench times each tick-mode update to the exact cycle after a divider write, and after the divider is re-enabled. A divider that did not restart on a write, or that ran at the wrong period, therefore shows the new level one or more cycles off. The bench sends a pulse that one tick catches and the next tick misses. It also sends a one-cycle glitch in clock mode. A filter that accepted a single sample would let either pulse through. The bench holds the divider off for many cycles to catch a tick that leaks while it is gated. It also loads a mixed select word, to expose filters that share the wrong timing between pins. Finally, it enables the select bits while filtering is off, to check that bypass really ignores them.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    typedef enum logic [1:0] {
        FM_BYPASS = 2'd0,
        FM_GLITCH = 2'd1,
        FM_TICK   = 2'd2
    } filt_mode_e;

    typedef struct packed {
        logic samp;
        logic level;
    } pin_state_t;

    function automatic filt_mode_e pick_mode(input logic en, input logic sel);
        if (!en)
            return FM_BYPASS;
        else if (sel)
            return FM_TICK;
        else
            return FM_GLITCH;
    endfunction

endpackage

// File: rtl/pdb_regs.sv
module pdb_regs #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic [NPINS-1:0] en_wdata,
    input  logic             sel_wr,
    input  logic [NPINS-1:0] sel_wdata,
    output logic [NPINS-1:0] en_q,
    output logic [NPINS-1:0] sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            if (en_wr)
                en_q <= en_wdata;
            if (sel_wr)
                sel_q <= sel_wdata;
        end
    end

endmodule

// File: rtl/pdb_divider.sv
module pdb_divider #(
    parameter int DIVW = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            div_wr,
    input  logic [DIVW-1:0] div_wdata,
    output logic            tick
);

    localparam int CW = DIVW + 1;

    logic [DIVW-1:0] div_q;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   last;

    // Count 0 .. 2*div+1, which is 2*(div+1) cycles per tick.
    assign last = {div_q, 1'b1};
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (div_wr) begin
            div_q <= div_wdata;
            cnt   <= '0;
        end else if (!run || tick) begin
            cnt   <= '0;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pdb_pin_filter.sv
module pdb_pin_filter
    import pdb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    input  filt_mode_e mode,
    input  logic       tick,
    output logic       level
);

    pin_state_t st;
    logic       step;

    always_comb begin
        case (mode)
            FM_TICK: step = tick;
            default: step = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (mode == FM_BYPASS) begin
            st.samp  <= raw;
            st.level <= raw;
        end else if (step) begin
            st.samp <= raw;
            if (raw == st.samp)
                st.level <= raw;
        end
    end

    assign level = st.level;

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank
    import pdb_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIVW  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] raw_pins,
    input  logic             en_wr,
    input  logic [NPINS-1:0] en_wdata,
    input  logic             sel_wr,
    input  logic [NPINS-1:0] sel_wdata,
    input  logic             div_wr,
    input  logic [DIVW-1:0]  div_wdata,
    input  logic             dbclk_en,
    output logic [NPINS-1:0] pins_filt
);

    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] sel_q;
    logic             tick;

    pdb_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .en_q      (en_q),
        .sel_q     (sel_q)
    );

    pdb_divider #(.DIVW(DIVW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (dbclk_en),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .tick      (tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        filt_mode_e mode;
        assign mode = pick_mode(en_q[i], sel_q[i]);

        pdb_pin_filter u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_pins[i]),
            .mode  (mode),
            .tick  (tick),
            .level (pins_filt[i])
        );
    end

endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
    parameter int NPINS = 32,
    parameter int DIVW  = 24
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] raw_pins,
    input logic             div_wr,
    input logic             dbclk_en,
    input logic [NPINS-1:0] pins_filt,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] sel_q,
    input logic             tick,
    input logic [DIVW:0]    cnt,
    input logic [DIVW-1:0]  div_q
);

    // R1: outputs are cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (pins_filt == '0));

    // R2: bypassed pins follow the previous raw sample
    a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pins_filt & ~$past(en_q)) == ($past(raw_pins) & ~$past(en_q))));

    // R3: any output change lands on the level seen at the previous edge
    a_r3_change_from_input: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pins_filt ^ $past(pins_filt)) & (pins_filt ^ $past(raw_pins))) == '0));

    // R4: count never runs past the terminal value
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= {div_q, 1'b1});

    // R5: tick-mode pins move only on tick edges
    a_r5_tick_only: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(tick) ||
                  (((pins_filt ^ $past(pins_filt)) & $past(en_q & sel_q)) == '0)));

    // R6: divider write restarts count
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> (cnt == '0));

    // R7: gated divider gives no tick and holds the count at zero
    a_r7_gated: assert property (@(posedge clk) disable iff (rst)
        !dbclk_en |-> !tick);
    a_r7_held: assert property (@(posedge clk) disable iff (rst)
        !dbclk_en |=> (cnt == '0));

endmodule

bind pin_debounce_bank pdb_checker #(.NPINS(NPINS), .DIVW(DIVW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .raw_pins  (raw_pins),
    .div_wr    (div_wr),
    .dbclk_en  (dbclk_en),
    .pins_filt (pins_filt),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .tick      (tick),
    .cnt       (u_div.cnt),
    .div_q     (u_div.div_q)
);

// File: tb/pin_debounce_bank_tb.sv
module pin_debounce_bank_tb;

    localparam int NP = 32;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] raw_pins = '0;
    logic          en_wr = 1'b0;
    logic [NP-1:0] en_wdata = '0;
    logic          sel_wr = 1'b0;
    logic [NP-1:0] sel_wdata = '0;
    logic          div_wr = 1'b0;
    logic [DW-1:0] div_wdata = '0;
    logic          dbclk_en = 1'b0;
    logic [NP-1:0] pins_filt;

    pin_debounce_bank #(.NPINS(NP), .DIVW(DW)) u_dut (
        .clk(clk), .rst(rst), .raw_pins(raw_pins),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .dbclk_en(dbclk_en), .pins_filt(pins_filt)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            due;
        logic [NP-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic push(input int due, input logic [NP-1:0] exp, input string tag);
        item_t it;
        it.due = due;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare due items at the falling edge
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                total++;
                if (pins_filt !== q[i].exp) begin
                    bad++;
                    $display("FAIL %s: cycle %0d got %h expected %h",
                             q[i].tag, cyc, pins_filt, q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic step_to(input int t);
        while (cyc < t) step();
    endtask

    task automatic finish_run();
        step();
        step();
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard: got %0d unchecked items expected 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] a, b, d, e, f;
        int w, x, g0, g, m, n, c, p, r;
        a = 32'h0F0F_3C3C;
        b = 32'hC3C3_A5A5;
        d = 32'h1234_5678;
        e = 32'hFFFF_0000;
        f = 32'hA5A5_5A5A;

        // R1: reset state
        step(); step();
        push(cyc, '0, "R1 in reset");
        step();
        rst = 1'b0;
        push(cyc + 1, '0, "R1 after reset");

        // R2: bypass, including a one-cycle pulse
        step();
        raw_pins = 32'h5A5A_00F0;
        push(cyc + 1, 32'h5A5A_00F0, "R2 follow");
        step();
        raw_pins = 32'h5A5A_00F8;
        push(cyc + 1, 32'h5A5A_00F8, "R2 pulse passes");
        step();
        raw_pins = 32'h5A5A_00F0;
        push(cyc + 1, 32'h5A5A_00F0, "R2 pulse ends");

        // R3 and R9: enable glitch mode
        step();
        en_wr = 1'b1; en_wdata = '1;
        step();
        en_wr = 1'b0;
        raw_pins = a;
        c = cyc;
        push(c + 1, 32'h5A5A_00F0, "R3 one sample held");
        push(c + 2, a, "R3 two samples accepted");
        step_to(c + 3);
        p = cyc;
        raw_pins = a ^ 32'h0000_0100;
        push(p + 1, a, "R3 glitch blocked 1");
        push(p + 2, a, "R3 glitch blocked 2");
        push(p + 3, a, "R3 glitch blocked 3");
        step();
        raw_pins = a;
        step_to(p + 4);
        r = cyc;
        raw_pins = a ^ 32'h1;
        push(r + 2, a ^ 32'h1, "R3 two-cycle level passes");
        push(r + 3, a ^ 32'h1, "R3 held after");
        push(r + 4, a, "R3 return");
        step();
        step();
        raw_pins = a;
        step_to(r + 6);

        // R4, R5, R6: tick mode with divider 2 (period 6)
        w = cyc;
        sel_wr = 1'b1; sel_wdata = '1;
        div_wr = 1'b1; div_wdata = 24'd2;
        dbclk_en = 1'b1;
        step();
        sel_wr = 1'b0; div_wr = 1'b0;
        step_to(w + 2);
        raw_pins = b;
        push(w + 12, a, "R4 before second tick");
        push(w + 13, b, "R5 second tick accepts");
        step_to(w + 14);
        raw_pins = b ^ 32'h0000_00FF;
        push(w + 18, b, "R5 pulse between ticks 1");
        push(w + 20, b, "R5 pulse between ticks 2");
        step_to(w + 17);
        raw_pins = b;
        step_to(w + 18);
        raw_pins = b ^ 32'h0000_FF00;
        push(w + 23, b, "R5 single tick sample 1");
        push(w + 27, b, "R5 single tick sample 2");
        push(w + 32, b, "R5 single tick sample 3");
        step_to(w + 22);
        raw_pins = b;
        step_to(w + 34);

        // R6: restart with divider 0 (period 2)
        x = cyc;
        div_wr = 1'b1; div_wdata = 24'd0;
        step();
        div_wr = 1'b0;
        raw_pins = d;
        push(x + 4, b, "R6 restart early");
        push(x + 5, d, "R6 restart tick");
        step_to(x + 8);

        // R7: gate the divider
        g0 = cyc;
        dbclk_en = 1'b0;
        step();
        raw_pins = e;
        push(g0 + 10, d, "R7 gated hold 1");
        push(g0 + 30, d, "R7 gated hold 2");
        step_to(g0 + 31);
        g = cyc;
        dbclk_en = 1'b1;
        push(g + 3, d, "R7 resume early");
        push(g + 4, e, "R7 resume accepts");
        step_to(g + 6);

        // R8: mixed select, divider 2
        m = cyc;
        sel_wr = 1'b1; sel_wdata = 32'hFFFF_0000;
        div_wr = 1'b1; div_wdata = 24'd2;
        step();
        sel_wr = 1'b0; div_wr = 1'b0;
        raw_pins = f;
        push(m + 3, {e[31:16], f[15:0]}, "R8 glitch half first");
        push(m + 12, {e[31:16], f[15:0]}, "R8 tick half waits");
        push(m + 13, f, "R8 tick half accepts");
        step_to(m + 15);

        // R2 and R9: disable filtering while select bits are set
        n = cyc;
        en_wr = 1'b1; en_wdata = '0;
        step();
        en_wr = 1'b0;
        raw_pins = 32'h0000_0001;
        push(n + 2, 32'h0000_0001, "R2 select ignored in bypass");
        step_to(n + 4);

        finish_run();
    end

endmodule